// File: doc/BRIEF.md
# Compare flags and branch resolver

This block keeps the relation flags produced by a compare and uses them to decide conditional branches. A compare strobe presents two 32-bit operands. The block stores five relation bits: signed greater, signed less, equal, unsigned greater and unsigned less. When the operands match, only the equal bit is kept.

A 16-bit instruction word comes in with a valid strobe and the address of that instruction. If the word belongs to the branch class, the block picks one of ten conditions and tests it against the stored flags. One cycle later it presents three outputs: a taken flag, the next instruction address and an illegal-instruction flag. The next address is the branch target when the branch is taken and the fall-through address otherwise.

Register-file reads and instruction fetch are handled elsewhere. The block sees only the operand values and the instruction word.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset the stored flags are all zero, and `br_taken`, `illegal_op` and `next_pc` are all zero.
- R2: A compare of two equal operands stores exactly the equal bit (bit 2) and clears every other flag bit.
- R3: A compare of unequal operands sets signed-greater (bit 0) or signed-less (bit 1) from a two's-complement comparison. Separately, it sets unsigned-greater (bit 3) or unsigned-less (bit 4) from an unsigned comparison, and it clears the equal bit.
- R4: The stored flags change only in a cycle where `cmp_en` is high. Operand values presented while `cmp_en` is low have no effect on later branch outcomes.
- R5: A valid instruction is treated as a branch only when bits 15 and 14 are both 1. Any other valid word gives `br_taken`=0, `illegal_op`=0 and `next_pc`=pc+2.
- R6: The condition code in bits 13:10 selects the branch condition as follows:
  - 0: equal
  - 1: not equal, taken when the equal bit is clear
  - 2: signed less
  - 3: signed greater
  - 4: unsigned less
  - 5: unsigned greater
  - 6: signed greater or equal
  - 7: signed less or equal
  - 8: unsigned greater or equal
  - 9: unsigned less or equal
  
  Codes 6 to 9 each test the named relation bit ORed with the equal bit.
- R7: A taken branch sets `next_pc` to pc plus bits 9:0 of the instruction, sign-extended and shifted left by one. The sum wraps modulo 2^32. A branch that is not taken sets `next_pc` to pc+2.
- R8: Branch condition codes 10 to 15 set `illegal_op` and leave `br_taken` at 0, with `next_pc`=pc+2.
- R9: Outputs are registered: they reflect an instruction presented with `instr_valid` one clock later. In a cycle after `instr_valid` was low, `br_taken` and `illegal_op` are 0 and `next_pc` keeps its value.
- R10: When a compare and a branch arrive on the same clock edge, the branch is resolved with the flags stored before that compare. The new flags apply from the next instruction on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_en | input | 1 | Compare strobe; loads the flags |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| instr_valid | input | 1 | Instruction word and pc are valid |
| instr | input | 16 | Instruction word |
| pc | input | 32 | Address of the instruction |
| br_taken | output | 1 | Branch condition held |
| next_pc | output | 32 | Target or fall-through address |
| illegal_op | output | 1 | Undefined branch condition code |

## Verification
A compare and a branch can land on the same edge. In that case the branch must see the old flags while the register takes the new ones. The bench provokes this by first leaving the flags in the equal state. It then issues, in a single cycle, a compare whose operands give signed-less together with an equal-branch. The equal-branch must be taken. The following equal-branch must fall through, and a less-branch must then be taken, which shows that the update still landed.

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int XLEN  = 32,
  parameter int ILEN  = 16,
  parameter int OFF_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_en,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic            instr_valid,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  output logic            br_taken,
  output logic [XLEN-1:0] next_pc,
  output logic            illegal_op
);
  localparam int SGT = 0, SLT = 1, EQ = 2, UGT = 3, ULT = 4;
  localparam int CODE_W   = ILEN - 2 - OFF_W;
  localparam int EXT_W    = XLEN - OFF_W - 1;
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  logic [4:0]        flags_q, flags_d;
  logic [CODE_W-1:0] code;
  logic              is_branch, cond_ok, code_bad;
  logic [XLEN-1:0]   offset, target, fall_through;

  always_comb begin
    flags_d = '0;
    if (opnd_a == opnd_b) flags_d[EQ] = 1'b1;
    else begin
      flags_d[SGT] = $signed(opnd_a) > $signed(opnd_b);
      flags_d[SLT] = $signed(opnd_a) < $signed(opnd_b);
      flags_d[UGT] = opnd_a > opnd_b;
      flags_d[ULT] = opnd_a < opnd_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flags_q <= '0;
    else if (cmp_en) flags_q <= flags_d;
  end

  assign is_branch = instr[ILEN-1] & instr[ILEN-2];
  assign code      = instr[ILEN-3 -: CODE_W];

  always_comb begin
    cond_ok  = 1'b0;
    code_bad = 1'b0;
    case (code)
      CODE_W'(0): cond_ok = flags_q[EQ];
      CODE_W'(1): cond_ok = !flags_q[EQ];
      CODE_W'(2): cond_ok = flags_q[SLT];
      CODE_W'(3): cond_ok = flags_q[SGT];
      CODE_W'(4): cond_ok = flags_q[ULT];
      CODE_W'(5): cond_ok = flags_q[UGT];
      CODE_W'(6): cond_ok = flags_q[SGT] | flags_q[EQ];
      CODE_W'(7): cond_ok = flags_q[SLT] | flags_q[EQ];
      CODE_W'(8): cond_ok = flags_q[UGT] | flags_q[EQ];
      CODE_W'(9): cond_ok = flags_q[ULT] | flags_q[EQ];
      default:    code_bad = 1'b1;
    endcase
  end

  assign offset       = {{EXT_W{instr[OFF_W-1]}}, instr[OFF_W-1:0], 1'b0};
  assign target       = pc + offset;
  assign fall_through = pc + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_taken   <= 1'b0;
      illegal_op <= 1'b0;
      next_pc    <= '0;
    end else if (instr_valid) begin
      br_taken   <= is_branch & cond_ok;
      illegal_op <= is_branch & code_bad;
      next_pc    <= (is_branch & cond_ok) ? target : fall_through;
    end else begin
      br_taken   <= 1'b0;
      illegal_op <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_branch_unit_chk.sv
module cmp_branch_unit_chk #(
  parameter int XLEN  = 32,
  parameter int ILEN  = 16,
  parameter int OFF_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmp_en,
  input logic            instr_valid,
  input logic [ILEN-1:0] instr,
  input logic [XLEN-1:0] pc,
  input logic            br_taken,
  input logic [XLEN-1:0] next_pc,
  input logic            illegal_op,
  input logic [4:0]      flags_q
);
  localparam int CODE_W = ILEN - 2 - OFF_W;
  wire is_br = instr[ILEN-1] & instr[ILEN-2];
  wire [CODE_W-1:0] cc = instr[ILEN-3 -: CODE_W];

  p_eq_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[2] |-> flags_q == 5'b00100);

  p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(flags_q));

  p_nonbranch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !is_br) |=> (!br_taken && !illegal_op && next_pc == $past(pc) + 2));

  p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_br) |=> (br_taken || next_pc == $past(pc) + 2));

  p_illegal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_br && cc > 9) |=> (illegal_op && !br_taken));

  p_illegal_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !br_taken);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!br_taken && !illegal_op && $stable(next_pc)));
endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(.XLEN(XLEN), .ILEN(ILEN), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .instr_valid(instr_valid),
  .instr(instr), .pc(pc), .br_taken(br_taken), .next_pc(next_pc),
  .illegal_op(illegal_op), .flags_q(flags_q)
);

// File: tb/cmp_branch_unit_test.sv
module cmp_branch_unit_test;
  logic        clk = 0, rst_n = 0, cmp_en = 0, instr_valid = 0;
  logic [31:0] opnd_a = 0, opnd_b = 0, pc = 0;
  logic [15:0] instr = 0;
  logic        br_taken, illegal_op;
  logic [31:0] next_pc;
  int n_chk = 0, n_fail = 0;
  logic [4:0] mf = 0;

  cmp_branch_unit uut (.clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .instr_valid(instr_valid), .instr(instr), .pc(pc),
    .br_taken(br_taken), .next_pc(next_pc), .illegal_op(illegal_op));

  always #2 clk = ~clk;

  function automatic logic [4:0] flags_of(logic [31:0] a, logic [31:0] b);
    if (a == b) return 5'b00100;
    return {a < b, a > b, 1'b0, $signed(a) < $signed(b), $signed(a) > $signed(b)};
  endfunction

  function automatic logic cond_of(logic [4:0] f, int c);
    case (c)
      0: return f[2];           1: return !f[2];
      2: return f[1];           3: return f[0];
      4: return f[4];           5: return f[3];
      6: return f[0] | f[2];    7: return f[1] | f[2];
      8: return f[3] | f[2];    9: return f[4] | f[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmp_en = 1; opnd_a = a; opnd_b = b;
    @(negedge clk);
    cmp_en = 0;
    mf = flags_of(a, b);
  endtask

  task automatic branch(int code, logic [9:0] off, logic [31:0] at, string tag);
    logic t, il;
    logic [31:0] tgt;
    t  = cond_of(mf, code);
    il = code > 9;
    tgt = t ? at + {{21{off[9]}}, off, 1'b0} : at + 2;
    @(negedge clk);
    instr_valid = 1; instr = {2'b11, 4'(code), off}; pc = at;
    @(negedge clk);
    instr_valid = 0;
    check({tag, " taken"}, 32'(br_taken), 32'(t));
    check({tag, " illegal"}, 32'(illegal_op), 32'(il));
    check({tag, " next_pc"}, next_pc, tgt);
  endtask

  task automatic all_codes(string tag);
    for (int c = 0; c < 10; c++) branch(c, 10'h010, 32'h0000_1000, tag);
  endtask

  task automatic t_reset;
    check("R1 taken", 32'(br_taken), 0);
    check("R1 illegal", 32'(illegal_op), 0);
    check("R1 next_pc", next_pc, 0);
    branch(0, 10'h004, 32'h100, "R1 beq after reset");
    branch(1, 10'h004, 32'h100, "R1 bne after reset");
  endtask

  task automatic t_equal;
    compare(32'd77, 32'd77);
    all_codes("R2 R6 equal");
    compare(32'h8000_0000, 32'h8000_0000);
    branch(7, 10'h020, 32'h2000, "R2 ble equal");
    branch(4, 10'h020, 32'h2000, "R2 bltu equal");
  endtask

  task automatic t_mixed;
    compare(32'hFFFF_FFFF, 32'd1);
    all_codes("R3 R6 neg vs pos");
    compare(32'd1, 32'h8000_0000);
    all_codes("R3 R6 pos vs min");
    compare(32'd3, 32'd9);
    all_codes("R3 R6 small");
  endtask

  task automatic t_hold;
    compare(32'd5, 32'd9);
    @(negedge clk);
    opnd_a = 32'd9; opnd_b = 32'd9;
    @(negedge clk);
    opnd_a = 32'd20; opnd_b = 32'd1;
    branch(2, 10'h008, 32'h3000, "R4 blt hold");
    branch(0, 10'h008, 32'h3000, "R4 beq hold");
  endtask

  task automatic t_nonbranch;
    @(negedge clk);
    instr_valid = 1; instr = 16'h8000; pc = 32'h400;
    @(negedge clk);
    instr_valid = 0;
    check("R5 bit15 only taken", 32'(br_taken), 0);
    check("R5 bit15 only next", next_pc, 32'h402);
    @(negedge clk);
    instr_valid = 1; instr = 16'h4000; pc = 32'h500;
    @(negedge clk);
    instr_valid = 0;
    check("R5 bit14 only illegal", 32'(illegal_op), 0);
    check("R5 bit14 only next", next_pc, 32'h502);
  endtask

  task automatic t_offsets;
    compare(32'd1, 32'd1);
    branch(0, 10'h1FF, 32'h1000, "R7 max forward");
    branch(0, 10'h200, 32'h1000, "R7 max backward");
    branch(0, 10'h3FF, 32'h1000, "R7 minus one");
    branch(0, 10'h3FE, 32'h0000_0002, "R7 wrap below zero");
    branch(1, 10'h1FF, 32'hFFFF_FFFE, "R7 not taken wrap");
  endtask

  task automatic t_illegal;
    for (int c = 10; c < 16; c++) branch(c, 10'h010, 32'h800, "R8 bad code");
  endtask

  task automatic t_idle;
    compare(32'd4, 32'd4);
    branch(0, 10'h040, 32'h6000, "R9 taken");
    @(negedge clk);
    check("R9 idle taken", 32'(br_taken), 0);
    check("R9 idle next held", next_pc, 32'h6080);
    branch(12, 10'h0, 32'h7000, "R9 illegal");
    @(negedge clk);
    check("R9 idle illegal", 32'(illegal_op), 0);
  endtask

  task automatic t_same_cycle;
    compare(32'd8, 32'd8);
    @(negedge clk);
    cmp_en = 1; opnd_a = 32'd1; opnd_b = 32'd2;
    instr_valid = 1; instr = {2'b11, 4'd0, 10'h010}; pc = 32'h9000;
    @(negedge clk);
    cmp_en = 0; instr_valid = 0;
    check("R10 old flags taken", 32'(br_taken), 1);
    check("R10 old flags next", next_pc, 32'h9020);
    mf = flags_of(32'd1, 32'd2);
    branch(0, 10'h010, 32'h9100, "R10 beq after");
    branch(2, 10'h010, 32'h9200, "R10 blt after");
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_equal;
    t_mixed;
    t_hold;
    t_nonbranch;
    t_offsets;
    t_illegal;
    t_idle;
    t_same_cycle;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule